// File: doc/BRIEF.md
# Edge-Filtered Status Group

This block watches a 16-bit vector of live status conditions and records selected changes in a sticky event register. Each bit has two filter bits. One arms capture of a 0-to-1 change and the other arms capture of a 1-to-0 change. Captured events stay set until software reads the event register or issues a clear-status command. An enable mask picks which latched events drive a single summary output. A chip instantiates one copy per status group and sets a parameter that marks which bits are implemented.

Software uses a small register port. It can write the two filters and the enable mask, and it can read any of the five registers. Reading the event register clears it. Two single-cycle command inputs are provided. Clear-status wipes the events. Preset loads the filters and the enable mask with defined values. A change is detected by comparing the live input with a copy registered one cycle earlier.

Top module: `status_group`

## Requirements
- R1: A read at address 0 (live condition) returns the masked `cond_i` sampled at the read edge on `rdata_o` one cycle later, and the read changes no register.
- R2: A bit whose rise filter (address 1) is 1 sets its event bit one clock after `cond_i` goes from 0 to 1 on that bit.
- R3: A bit whose fall filter (address 2) is 1 sets its event bit one clock after `cond_i` goes from 1 to 0; with the fall filter 0, a falling change records nothing.
- R4: With both filters set for a bit, both directions of change are captured; with neither set, no change is captured.
- R5: Event bits (address 3) stay set until an event read or `clr_i`; `clr_i` clears all of them; writes to address 3 or address 0 have no effect.
- R6: An event read returns the events held before that edge and clears them, except an edge detected in that same cycle, which stays latched.
- R7: The rise and fall filters keep their values through event reads, `clr_i` and `rst_n`.
- R8: `preset_i` loads the fall filter with 0, the rise filter with all implemented bits and the enable mask (address 4) with 0, and leaves the events untouched; preset wins over a same-cycle write.
- R9: `summary_o` is high exactly when some event bit and its enable bit are both 1, valid in the cycle after the event or enable register updates.
- R10: Bit 15 and every bit outside `IMPL_MASK` read as 0 in all registers and never record an event.
- R11: Reset clears the events, the enable mask, the previous-condition copy and `rdata_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cond_i | input | 16 | Live status conditions |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 3 | Register address: 0 condition, 1 rise filter, 2 fall filter, 3 events, 4 enable |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, registered |
| clr_i | input | 1 | Clear-status command |
| preset_i | input | 1 | Preset command |
| summary_o | output | 1 | OR of enabled events |

## Verification
Each read returns its data after one clock edge. The bench applies the read strobe at a falling edge, and its monitor pops the expected word at the next falling edge. A condition change applied at a falling edge is latched at the following rising edge. The bench therefore samples the summary at the falling edge after that and never earlier. It issues event reads only after that same edge, except in the collision case, where the change and the read share one cycle on purpose.

// File: rtl/stsg_pkg.sv
package stsg_pkg;
  localparam int SG_W = 16;

  typedef enum logic [2:0] {
    SG_COND   = 3'd0,
    SG_RISE   = 3'd1,
    SG_FALL   = 3'd2,
    SG_EVENT  = 3'd3,
    SG_ENABLE = 3'd4
  } sg_addr_e;

  function automatic logic [SG_W-1:0] sg_hits(
    input logic [SG_W-1:0] prev,
    input logic [SG_W-1:0] curr,
    input logic [SG_W-1:0] rise,
    input logic [SG_W-1:0] fall,
    input logic [SG_W-1:0] mask
  );
    return mask & ((~prev & curr & rise) | (prev & ~curr & fall));
  endfunction

  function automatic logic sg_summary(
    input logic [SG_W-1:0] evt,
    input logic [SG_W-1:0] en
  );
    return |(evt & en);
  endfunction
endpackage

// File: rtl/sg_edge_detect.sv
module sg_edge_detect
  import stsg_pkg::*;
#(
  parameter logic [SG_W-1:0] MASK = '1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SG_W-1:0] cond_i,
  input  logic [SG_W-1:0] rise_f_i,
  input  logic [SG_W-1:0] fall_f_i,
  output logic [SG_W-1:0] hits_o
);
  logic [SG_W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= cond_i;
  end

  assign hits_o = sg_hits(prev_q, cond_i, rise_f_i, fall_f_i, MASK);

  // R10: a hit can only appear on an implemented bit
  a_r10_hits_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (hits_o & ~MASK) == '0);
  // R4: a bit that has not changed never produces a hit
  a_r4_no_change_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (hits_o & ~(prev_q ^ cond_i)) == '0);
endmodule

// File: rtl/sg_event_latch.sv
module sg_event_latch
  import stsg_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SG_W-1:0] hits_i,
  input  logic            wipe_i,
  output logic [SG_W-1:0] evt_o
);
  for (genvar b = 0; b < SG_W; b++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         bit_q <= 1'b0;
      else if (hits_i[b]) bit_q <= 1'b1;
      else if (wipe_i)    bit_q <= 1'b0;
    end
    assign evt_o[b] = bit_q;
  end

  // R5: without a wipe, set events stay set
  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !wipe_i |=> ((evt_o & $past(evt_o)) == $past(evt_o)));
  // R6: a hit is latched even when a wipe arrives in the same cycle
  a_r6_hit_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (hits_i != '0) |=> ((evt_o & $past(hits_i)) == $past(hits_i)));
  // R5: a wipe with no hit leaves the register empty
  a_r5_wipe: assert property (@(posedge clk) disable iff (!rst_n)
    (wipe_i && hits_i == '0) |=> evt_o == '0);
endmodule

// File: rtl/sg_ctrl_regs.sv
module sg_ctrl_regs
  import stsg_pkg::*;
#(
  parameter logic [SG_W-1:0] MASK = '1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en_i,
  input  logic [2:0]      addr_i,
  input  logic [SG_W-1:0] wdata_i,
  input  logic            preset_i,
  output logic [SG_W-1:0] rise_o,
  output logic [SG_W-1:0] fall_o,
  output logic [SG_W-1:0] en_o
);
  logic wr_rise, wr_fall, wr_en;
  assign wr_rise = wr_en_i && (addr_i == SG_RISE);
  assign wr_fall = wr_en_i && (addr_i == SG_FALL);
  assign wr_en   = wr_en_i && (addr_i == SG_ENABLE);

  // Filters carry no reset: reset must leave them as they were.
  always_ff @(posedge clk) begin
    if (preset_i) begin
      rise_o <= MASK;
      fall_o <= '0;
    end else begin
      if (wr_rise) rise_o <= wdata_i & MASK;
      if (wr_fall) fall_o <= wdata_i & MASK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        en_o <= '0;
    else if (preset_i) en_o <= '0;
    else if (wr_en)    en_o <= wdata_i & MASK;
  end

  // R8: preset values
  a_r8_preset: assert property (@(posedge clk) disable iff (!rst_n)
    preset_i |=> (rise_o == MASK && fall_o == '0 && en_o == '0));
  // R7: filters move only on their own write or on preset
  a_r7_rise_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_rise && !preset_i) |=> $stable(rise_o));
  a_r7_fall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_fall && !preset_i) |=> $stable(fall_o));
endmodule

// File: rtl/status_group.sv
module status_group
  import stsg_pkg::*;
#(
  parameter logic [15:0] IMPL_MASK = 16'h02B8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] cond_i,
  input  logic        wr_en_i,
  input  logic        rd_en_i,
  input  logic [2:0]  addr_i,
  input  logic [15:0] wdata_i,
  output logic [15:0] rdata_o,
  input  logic        clr_i,
  input  logic        preset_i,
  output logic        summary_o
);
  localparam logic [SG_W-1:0] EFF_MASK = IMPL_MASK & ~(16'h1 << (SG_W-1));

  logic [SG_W-1:0] rise_f, fall_f, en_q, evt_q, hits;
  logic            evt_read, wipe;
  logic [SG_W-1:0] rd_mux;

  sg_ctrl_regs #(.MASK(EFF_MASK)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .preset_i(preset_i),
    .rise_o(rise_f), .fall_o(fall_f), .en_o(en_q)
  );

  sg_edge_detect #(.MASK(EFF_MASK)) u_edge (
    .clk(clk), .rst_n(rst_n), .cond_i(cond_i),
    .rise_f_i(rise_f), .fall_f_i(fall_f), .hits_o(hits)
  );

  assign evt_read = rd_en_i && (addr_i == SG_EVENT);
  assign wipe     = evt_read || clr_i;

  sg_event_latch u_evt (
    .clk(clk), .rst_n(rst_n), .hits_i(hits), .wipe_i(wipe), .evt_o(evt_q)
  );

  always_comb begin
    unique case (addr_i)
      SG_COND:   rd_mux = cond_i & EFF_MASK;
      SG_RISE:   rd_mux = rise_f;
      SG_FALL:   rd_mux = fall_f;
      SG_EVENT:  rd_mux = evt_q;
      SG_ENABLE: rd_mux = en_q;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_mux;
  end

  assign summary_o = sg_summary(evt_q, en_q);

  // R1: condition read returns the masked input seen at the read edge
  a_r1_cond_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && addr_i == SG_COND) |=> rdata_o == ($past(cond_i) & EFF_MASK));
  // R10: no unimplemented bit ever appears on the read port
  a_r10_rdata_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata_o & ~EFF_MASK) == '0);
  // R9: summary implies an enabled event exists
  a_r9_summary: assert property (@(posedge clk) disable iff (!rst_n)
    summary_o |-> (evt_q != '0 && en_q != '0));
endmodule

// File: tb/status_group_bench.sv
module status_group_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] MASK = 16'h02B8;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] cond_i = 0;
  logic        wr_en_i = 0, rd_en_i = 0, clr_i = 0, preset_i = 0;
  logic [2:0]  addr_i = 0;
  logic [15:0] wdata_i = 0;
  logic [15:0] rdata_o;
  logic        summary_o;

  int checks = 0, fails = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic        rd_fire = 0;
  bit          done = 0;

  status_group #(.IMPL_MASK(MASK)) u_status_group (
    .clk(clk), .rst_n(rst_n), .cond_i(cond_i), .wr_en_i(wr_en_i),
    .rd_en_i(rd_en_i), .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .clr_i(clr_i), .preset_i(preset_i), .summary_o(summary_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) rd_fire <= rd_en_i;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: one read result due at the falling edge after the read edge
  always @(negedge clk) begin
    if (rd_fire) begin
      if (exp_q.size() == 0) check("scoreboard-empty", 16'h1, 16'h0);
      else check(tag_q.pop_front(), rdata_o, exp_q.pop_front());
    end
  end

  task automatic do_read(input logic [2:0] a, input logic [15:0] exp, input string tag);
    rd_en_i = 1; addr_i = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(posedge clk); @(negedge clk);
    rd_en_i = 0;
  endtask

  task automatic do_write(input logic [2:0] a, input logic [15:0] d);
    wr_en_i = 1; addr_i = a; wdata_i = d;
    @(posedge clk); @(negedge clk);
    wr_en_i = 0;
  endtask

  task automatic pulse_clr();
    clr_i = 1; @(posedge clk); @(negedge clk); clr_i = 0;
  endtask

  task automatic pulse_preset();
    preset_i = 1; @(posedge clk); @(negedge clk); preset_i = 0;
  endtask

  task automatic set_cond(input logic [15:0] c);
    cond_i = c; @(posedge clk); @(negedge clk);
  endtask

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      finish_run();
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    check("R11 rdata at reset", rdata_o, 16'h0);
    check("R11 summary at reset", {15'h0, summary_o}, 16'h0);
    rst_n = 1;
    @(negedge clk);
    pulse_preset();
    do_read(3'd1, MASK, "R8 rise filter after preset");
    do_read(3'd2, 16'h0, "R8 fall filter after preset");
    do_read(3'd4, 16'h0, "R8 enable after preset");

    // R2 rising capture
    set_cond(16'h0008);
    do_read(3'd3, 16'h0008, "R2 rising edge captured");
    do_read(3'd3, 16'h0000, "R6 event read is destructive");

    // R10 / R1: unimplemented bits on the input
    set_cond(16'h8009);
    do_read(3'd0, 16'h0008, "R1 R10 condition read masked");
    do_read(3'd3, 16'h0000, "R10 unimplemented bits record nothing");

    // R3 fall with fall filter clear
    set_cond(16'h0000);
    do_read(3'd3, 16'h0000, "R3 falling ignored when fall filter 0");

    // R3 fall-only
    do_write(3'd1, 16'h0000);
    do_write(3'd2, 16'h0008);
    set_cond(16'h0008);
    do_read(3'd3, 16'h0000, "R3 rising ignored with fall-only filter");
    set_cond(16'h0000);
    do_read(3'd3, 16'h0008, "R3 falling captured");

    // R4 both directions
    do_write(3'd1, 16'h0008);
    set_cond(16'h0008);
    do_read(3'd3, 16'h0008, "R4 both: rise captured");
    set_cond(16'h0000);
    do_read(3'd3, 16'h0008, "R4 both: fall captured");
    do_write(3'd1, 16'h0000);
    do_write(3'd2, 16'h0000);
    set_cond(16'h0008);
    set_cond(16'h0000);
    do_read(3'd3, 16'h0000, "R4 neither filter: nothing captured");

    // R5 sticky, write ignored, clear
    do_write(3'd1, 16'h0020);
    set_cond(16'h0020);
    set_cond(16'h0000);
    wait_cycles(4);
    do_write(3'd3, 16'h0000);
    do_write(3'd0, 16'hFFFF);
    do_read(3'd3, 16'h0020, "R5 event stays set, writes ignored");
    do_write(3'd3, 16'hFFFF);
    do_read(3'd3, 16'h0000, "R5 write to event register ignored");
    set_cond(16'h0020);
    pulse_clr();
    do_read(3'd3, 16'h0000, "R5 clear-status wipes events");

    // R6 edge in the same cycle as an event read
    set_cond(16'h0000);
    cond_i = 16'h0020;
    do_read(3'd3, 16'h0000, "R6 read returns pre-edge events");
    do_read(3'd3, 16'h0020, "R6 same-cycle edge retained");

    // R9 summary
    set_cond(16'h0000);
    set_cond(16'h0020);
    check("R9 summary low when not enabled", {15'h0, summary_o}, 16'h0);
    do_write(3'd4, 16'h0020);
    check("R9 summary high when enabled", {15'h0, summary_o}, 16'h1);
    do_write(3'd4, 16'h0008);
    check("R9 summary low with other enable", {15'h0, summary_o}, 16'h0);
    do_write(3'd4, 16'h0020);
    do_read(3'd3, 16'h0020, "R9 read before summary drop");
    check("R9 summary drops after read", {15'h0, summary_o}, 16'h0);

    // R10 masked filter write
    do_write(3'd2, 16'hFFFF);
    do_read(3'd2, MASK, "R10 fall filter masked");

    // R8 preset leaves events, beats write
    set_cond(16'h0000);
    set_cond(16'h0020);
    preset_i = 1; wr_en_i = 1; addr_i = 3'd4; wdata_i = 16'h0020;
    @(posedge clk); @(negedge clk);
    preset_i = 0; wr_en_i = 0;
    do_read(3'd4, 16'h0000, "R8 preset wins over enable write");
    do_read(3'd3, 16'h0020, "R8 preset keeps events");

    // R7 filters through clear and reset
    do_write(3'd1, 16'h0208);
    do_write(3'd2, 16'h0080);
    do_write(3'd4, 16'h0200);
    pulse_clr();
    do_read(3'd1, 16'h0208, "R7 rise filter after clear");
    set_cond(16'h0000);
    rst_n = 0;
    @(negedge clk);
    check("R11 rdata cleared by reset", rdata_o, 16'h0);
    rst_n = 1;
    @(negedge clk);
    do_read(3'd1, 16'h0208, "R7 rise filter survives reset");
    do_read(3'd2, 16'h0080, "R7 fall filter survives reset");
    do_read(3'd4, 16'h0000, "R11 enable cleared by reset");
    do_read(3'd3, 16'h0000, "R11 events cleared by reset");

    @(negedge clk);
    done = 1;
    finish_run();
  end
endmodule